// File: doc/BRIEF.md
# DMA Instruction Sequencer

This block walks a program of 32-bit instruction words held in an external instruction memory. It fetches the words one at a time through a valid/ready fetch channel. Each instruction is one to four words long, and the opcode in the first word sets the length. A write instruction becomes a transfer request that is presented to a downstream mover on a valid/ready channel. A jump reloads the program counter. A control-register instruction performs a masked update of one register in a small internal bank. The block carries out no data movement itself.

Flag bits in the command word take effect when the instruction finishes. They set sticky interrupt status bits, which the host clears by writing ones. They also increment or clear a 16-bit event counter. A buffer-completion output compares that counter against a host-supplied target with a signed 16-bit difference, so the comparison stays correct when the counter wraps. A program can park itself by jumping to its own address. It runs until a stop request, which takes effect at the next instruction boundary.

Back-pressure rules:
- Fetch channel: a word is consumed only in a cycle where `fetch_valid` and `fetch_ready` are both high.
- Transfer channel: once `xfer_valid` rises it stays high, with address, count and markers unchanged, until `xfer_ready` is seen. No fetch happens in that time.

Top module: `dma_seq`

## Requirements
- R1: The fetch address equals the program counter. A word is taken only when `fetch_valid` and `fetch_ready` are both high, and each taken word advances the counter by 4.
- R2: The opcode is bits 31:28 of the first word. The instruction length follows from it:
  - write (1) and jump (7): two words
  - opcodes 0xB and 0xC: three words (no action besides flags)
  - control-register write (0xD): four words
  - opcodes 2, 5, 8, 9 and 0xA: one word (no action besides flags)
- R3: A write instruction raises `xfer_valid` with:
  - count from bits 11:0
  - address from the second word
  - start-of-line marker from bit 27
  - end-of-line marker from bit 26

  It holds all of these stable, and fetches nothing, until `xfer_ready`.
- R4: A jump loads the program counter from the low bits of its second word, so a jump to itself parks the program.
- R5: A control-register write uses its words in this order: command, address, value, mask. Address bits [IW+1:2] select the register, and that register becomes (old & ~mask) | (value & mask). No other register changes.
- R6: Bit 24 (irq1) and bit 25 (irq2) set sticky status bits when the instruction completes. A write completes at its transfer handshake. Writing a one to `irq_clr` bit 0, 1 or 2 clears irq1, irq2 or error respectively. A set in the same cycle wins over a clear.
- R7: Bit 16 increments the 16-bit event counter at completion, wrapping from 0xFFFF to 0. Bit 17 clears it, and a clear wins over an increment. Otherwise the counter holds.
- R8: `buf_done` is high exactly when (evt_cnt - buf_target), taken as a signed 16-bit value, is zero or positive.
- R9: Opcodes 0, 3, 4, 6, 0xE and 0xF set the error status bit and halt the sequencer. While halted there is no fetch and `busy` is low, until the next start.
- R10: `start` while not busy loads the program counter from `start_addr` and begins fetching; `start` while busy is ignored. `stop` ends execution at the next instruction completion and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin execution at start_addr |
| start_addr | input | AW | Initial program address |
| stop | input | 1 | Halt at the next instruction boundary |
| fetch_valid | output | 1 | Instruction word wanted |
| fetch_ready | input | 1 | fetch_data is valid this cycle |
| fetch_addr | output | AW | Byte address of wanted word |
| fetch_data | input | 32 | Instruction word |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 32 | Transfer target address |
| xfer_count | output | 12 | Transfer byte count |
| xfer_sol | output | 1 | Start-of-line marker |
| xfer_eol | output | 1 | End-of-line marker |
| creg_q | output | NCREG*32 | Control register bank, register i at bits [32i+31:32i] |
| irq_clr | input | 3 | Write-one-to-clear: bit0 irq1, bit1 irq2, bit2 error |
| irq1_st | output | 1 | Sticky irq1 status |
| irq2_st | output | 1 | Sticky irq2 status |
| err_st | output | 1 | Sticky undefined-opcode status |
| evt_cnt | output | 16 | Event counter |
| buf_target | input | 16 | Buffer target count |
| buf_done | output | 1 | Buffer target reached |
| pc | output | AW | Program counter |
| busy | output | 1 | Fetching or waiting on a transfer |

## Verification
Assertions check the following on every cycle:
- the transfer request stays stable under back-pressure
- each fetched word steps the program counter by four
- a jump lands on its operand
- a halt leaves the fetch channel quiet
- the sticky bits persist unless cleared
- the event counter and the register bank change only on completion or a write

The bench scenarios supply what the assertions cannot: correct instruction lengths across a mixed program, exact register values after masked updates, and a full wrap of the event counter. Across that wrap, the bench checks `buf_done` on every cycle against targets at the edges of the signed window. The bench scenarios also cover the start-while-busy and stop-at-boundary sequences.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_HALT} seq_state_e;

  typedef enum logic [2:0] {K_NOP, K_WRITE, K_JUMP, K_CREG, K_BAD} op_kind_e;

  localparam logic [3:0] OP_WRITE = 4'h1;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CREG  = 4'hD;

  typedef struct packed {
    logic [3:0]  op;
    logic        sol;
    logic        eol;
    logic        irq2;
    logic        irq1;
    logic        clr;
    logic        inc;
    logic [11:0] cnt;
  } cmd_t;

  typedef struct packed {
    logic irq1;
    logic irq2;
    logic clr;
    logic inc;
  } done_flags_t;

endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
  import dma_seq_pkg::*;
(
  input  logic [3:0] opcode,
  output op_kind_e   kind,
  output logic [2:0] nwords
);

  always_comb begin
    kind   = K_NOP;
    nwords = 3'd1;
    unique case (opcode)
      OP_WRITE: begin kind = K_WRITE; nwords = 3'd2; end
      OP_JUMP:  begin kind = K_JUMP;  nwords = 3'd2; end
      4'hB, 4'hC: begin kind = K_NOP; nwords = 3'd3; end
      OP_CREG:  begin kind = K_CREG;  nwords = 3'd4; end
      4'h2, 4'h5, 4'h8, 4'h9, 4'hA: begin kind = K_NOP; nwords = 3'd1; end
      default:  begin kind = K_BAD;   nwords = 3'd1; end
    endcase
  end

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          stop,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr,
  input  logic [31:0]   fetch_data,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [31:0]   xfer_addr,
  output logic [11:0]   xfer_count,
  output logic          xfer_sol,
  output logic          xfer_eol,
  output logic [AW-1:0] pc,
  output logic          busy,
  output logic          done,
  output done_flags_t   done_flags,
  output logic          err_set,
  output logic          creg_we,
  output logic [IW-1:0] creg_idx,
  output logic [31:0]   creg_val,
  output logic [31:0]   creg_mask
);

  localparam logic [AW-1:0] PC_STEP = AW'(4);

  seq_state_e  state;
  logic [1:0]  idx;
  cmd_t        w0;
  logic [31:0] w1, w2;
  logic        stop_pend;

  cmd_t        cur;
  cmd_t        dcmd;
  op_kind_e    kind;
  logic [2:0]  nwords;
  logic        take, last;

  assign cur = (idx == 2'd0) ?
    '{op: fetch_data[31:28], sol: fetch_data[27], eol: fetch_data[26],
      irq2: fetch_data[25], irq1: fetch_data[24], clr: fetch_data[17],
      inc: fetch_data[16], cnt: fetch_data[11:0]} : w0;

  dma_seq_decode u_dec (.opcode(cur.op), .kind(kind), .nwords(nwords));

  assign fetch_valid = (state == ST_FETCH);
  assign fetch_addr  = pc;
  assign take        = fetch_valid && fetch_ready;
  assign last        = take && ({1'b0, idx} == nwords - 3'd1);
  assign err_set     = take && (idx == 2'd0) && (kind == K_BAD);

  assign xfer_valid  = (state == ST_XFER);
  assign xfer_addr   = w1;
  assign xfer_count  = w0.cnt;
  assign xfer_sol    = w0.sol;
  assign xfer_eol    = w0.eol;
  assign busy        = (state == ST_FETCH) || (state == ST_XFER);

  assign done = (last && kind != K_WRITE && kind != K_BAD) ||
                (xfer_valid && xfer_ready);
  assign dcmd = xfer_valid ? w0 : cur;
  assign done_flags = '{irq1: dcmd.irq1, irq2: dcmd.irq2,
                        clr: dcmd.clr, inc: dcmd.inc};

  assign creg_we   = last && (kind == K_CREG);
  assign creg_idx  = w1[IW+1:2];
  assign creg_val  = w2;
  assign creg_mask = fetch_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pc        <= '0;
      idx       <= '0;
      w0        <= '0;
      w1        <= '0;
      w2        <= '0;
      stop_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            pc        <= start_addr;
            idx       <= '0;
            stop_pend <= 1'b0;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (stop) stop_pend <= 1'b1;
          if (take) begin
            pc <= pc + PC_STEP;
            unique case (idx)
              2'd0:    w0 <= cur;
              2'd1:    w1 <= fetch_data;
              default: w2 <= fetch_data;
            endcase
            idx <= idx + 2'd1;
            if (err_set) begin
              idx   <= '0;
              state <= ST_HALT;
            end else if (last) begin
              idx <= '0;
              if (kind == K_WRITE) begin
                state <= ST_XFER;
              end else begin
                if (kind == K_JUMP) pc <= fetch_data[AW-1:0];
                if (stop_pend || stop) state <= ST_IDLE;
              end
            end
          end
        end
        ST_XFER: begin
          if (stop) stop_pend <= 1'b1;
          if (xfer_ready) state <= (stop_pend || stop) ? ST_IDLE : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_count) && !fetch_valid); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !last && !err_set |=> pc == $past(pc) + PC_STEP); // R1
  AST_JUMP_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    last && kind == K_JUMP |=> pc == $past(fetch_data[AW-1:0])); // R4
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> !fetch_valid && !busy); // R9

endmodule

// File: rtl/dma_seq_creg.sv
module dma_seq_creg #(
  parameter int NCREG = 4,
  parameter int IW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [31:0]       val,
  input  logic [31:0]       mask,
  output logic [NCREG*32-1:0] q
);

  for (genvar i = 0; i < NCREG; i++) begin : g_reg
    logic [31:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        r <= '0;
      else if (we && idx == IW'(i))      r <= (r & ~mask) | (val & mask);
    end
    assign q[i*32 +: 32] = r;
  end

  AST_CREG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R5

endmodule

// File: rtl/dma_seq_status.sv
module dma_seq_status
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  done_flags_t done_flags,
  input  logic        err_set,
  input  logic [2:0]  irq_clr,
  input  logic [15:0] buf_target,
  output logic        irq1_st,
  output logic        irq2_st,
  output logic        err_st,
  output logic [15:0] evt_cnt,
  output logic        buf_done
);

  logic [15:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq1_st <= 1'b0;
      irq2_st <= 1'b0;
      err_st  <= 1'b0;
      evt_cnt <= '0;
    end else begin
      irq1_st <= (irq1_st & ~irq_clr[0]) | (done & done_flags.irq1);
      irq2_st <= (irq2_st & ~irq_clr[1]) | (done & done_flags.irq2);
      err_st  <= (err_st  & ~irq_clr[2]) | err_set;
      if (done && done_flags.clr)      evt_cnt <= '0;
      else if (done && done_flags.inc) evt_cnt <= evt_cnt + 16'd1;
    end
  end

  assign diff     = evt_cnt - buf_target;
  assign buf_done = ~diff[15];

  AST_STICKY_IRQ1: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_st && !irq_clr[0] |=> irq1_st); // R6
  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_st && !irq_clr[2] |=> err_st); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(evt_cnt)); // R7

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NCREG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       start_addr,
  input  logic                stop,
  output logic                fetch_valid,
  input  logic                fetch_ready,
  output logic [AW-1:0]       fetch_addr,
  input  logic [31:0]         fetch_data,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [31:0]         xfer_addr,
  output logic [11:0]         xfer_count,
  output logic                xfer_sol,
  output logic                xfer_eol,
  output logic [NCREG*32-1:0] creg_q,
  input  logic [2:0]          irq_clr,
  output logic                irq1_st,
  output logic                irq2_st,
  output logic                err_st,
  output logic [15:0]         evt_cnt,
  input  logic [15:0]         buf_target,
  output logic                buf_done,
  output logic [AW-1:0]       pc,
  output logic                busy
);

  localparam int IW = (NCREG > 1) ? $clog2(NCREG) : 1;

  logic        done, err_set, creg_we;
  done_flags_t done_flags;
  logic [IW-1:0] creg_idx;
  logic [31:0] creg_val, creg_mask;

  dma_seq_ctl #(.AW(AW), .IW(IW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stop(stop),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .xfer_sol(xfer_sol),
    .xfer_eol(xfer_eol), .pc(pc), .busy(busy), .done(done), .done_flags(done_flags),
    .err_set(err_set), .creg_we(creg_we), .creg_idx(creg_idx),
    .creg_val(creg_val), .creg_mask(creg_mask)
  );

  dma_seq_creg #(.NCREG(NCREG), .IW(IW)) u_creg (
    .clk(clk), .rst_n(rst_n), .we(creg_we), .idx(creg_idx),
    .val(creg_val), .mask(creg_mask), .q(creg_q)
  );

  dma_seq_status u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .done_flags(done_flags),
    .err_set(err_set), .irq_clr(irq_clr), .buf_target(buf_target),
    .irq1_st(irq1_st), .irq2_st(irq2_st), .err_st(err_st),
    .evt_cnt(evt_cnt), .buf_done(buf_done)
  );

endmodule

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic        stop = 1'b0;
  logic        fetch_valid, fetch_ready = 1'b1;
  logic [15:0] fetch_addr;
  logic [31:0] fetch_data;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [11:0] xfer_count;
  logic        xfer_sol, xfer_eol;
  logic [127:0] creg_q;
  logic [2:0]  irq_clr = '0;
  logic        irq1_st, irq2_st, err_st;
  logic [15:0] evt_cnt;
  logic [15:0] buf_target = '0;
  logic        buf_done;
  logic [15:0] pc;
  logic        busy;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:63];
  assign fetch_data = mem[fetch_addr[7:2]];

  always #2 clk = ~clk;

  dma_seq i_dma_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stop(stop),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .xfer_sol(xfer_sol),
    .xfer_eol(xfer_eol), .creg_q(creg_q), .irq_clr(irq_clr), .irq1_st(irq1_st),
    .irq2_st(irq2_st), .err_st(err_st), .evt_cnt(evt_cnt), .buf_target(buf_target),
    .buf_done(buf_done), .pc(pc), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic sol, input logic eol,
                                     input logic irq2, input logic irq1, input logic clr,
                                     input logic inc, input logic [11:0] cnt);
    mk = {op, sol, eol, irq2, irq1, 6'd0, clr, inc, 4'd0, cnt};
  endfunction

  // ready drivers and R3 hold check
  int          xdelay = 3;
  int          wcnt = 0;
  logic        rdy_mode = 1'b0;
  logic [31:0] hold_addr = '0;
  always @(negedge clk) begin
    if (xfer_valid) begin
      if (wcnt > 0) begin
        chk("R3 xfer_addr held", xfer_addr, hold_addr);
        chk("R3 no fetch while xfer", {31'd0, fetch_valid}, 32'd0);
      end
      hold_addr = xfer_addr;
      wcnt++;
    end else begin
      wcnt = 0;
    end
    xfer_ready = xfer_valid && (wcnt > xdelay);
    fetch_ready = rdy_mode ? ~fetch_ready : 1'b1;
  end

  // transfer log
  logic [31:0] lg_addr [0:7];
  logic [11:0] lg_cnt  [0:7];
  logic [1:0]  lg_mark [0:7];
  int nlog = 0;
  always @(posedge clk) begin
    if (xfer_valid && xfer_ready && nlog < 8) begin
      lg_addr[nlog] = xfer_addr;
      lg_cnt[nlog]  = xfer_count;
      lg_mark[nlog] = {xfer_sol, xfer_eol};
      nlog++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] a);
    @(negedge clk); start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    #780000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = mk(4'h8, 0, 0, 0, 0, 0, 0, 12'd0);
    // program A at 0x00
    mem[0]  = mk(4'h1, 1, 1, 0, 1, 0, 0, 12'd100);
    mem[1]  = 32'h0000_1000;
    mem[2]  = mk(4'h1, 0, 0, 0, 0, 0, 1, 12'd8);
    mem[3]  = 32'h0000_2040;
    mem[4]  = mk(4'hD, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[5]  = 32'h0000_0008;
    mem[6]  = 32'hAAAA_5555;
    mem[7]  = 32'h0000_FFFF;
    mem[8]  = mk(4'hD, 0, 0, 1, 0, 0, 0, 12'd0);
    mem[9]  = 32'h0000_0008;
    mem[10] = 32'h1234_5678;
    mem[11] = 32'hFF00_0000;
    mem[12] = mk(4'hB, 0, 0, 0, 0, 0, 1, 12'd0);
    mem[13] = 32'hF000_0000;
    mem[14] = 32'hE000_0000;
    mem[15] = mk(4'h8, 0, 0, 0, 0, 0, 1, 12'd0);
    mem[16] = mk(4'h7, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[17] = 32'h0000_0040;
    // program B at 0x80: undefined opcode
    mem[32] = mk(4'h8, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[33] = 32'hE000_0000;
    // program C at 0x88: park
    mem[34] = mk(4'h7, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[35] = 32'h0000_0088;
    // program D at 0x90: clear, then 16 increments per loop
    mem[36] = mk(4'h8, 0, 0, 0, 0, 1, 1, 12'd0);
    for (int i = 37; i <= 52; i++) mem[i] = mk(4'h8, 0, 0, 0, 0, 0, 1, 12'd0);
    mem[53] = mk(4'h7, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[54] = 32'h0000_0094;

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("reset busy", {31'd0, busy}, 0);
    chk("reset fetch_valid R1", {31'd0, fetch_valid}, 0);
    chk("reset status R6", {29'd0, irq1_st, irq2_st, err_st}, 0);
    chk("reset evt_cnt R7", {16'd0, evt_cnt}, 0);
    chk("reset creg R5", creg_q[31:0] | creg_q[63:32] | creg_q[95:64] | creg_q[127:96], 0);

    // scenario 1: mixed program with fetch back-pressure
    rdy_mode = 1'b1;
    pulse_start(16'h0000);
    cyc(200);
    chk("R3 xfer count", nlog, 2);
    chk("R3 xfer0 addr", lg_addr[0], 32'h0000_1000);
    chk("R3 xfer0 count", {20'd0, lg_cnt[0]}, 100);
    chk("R3 xfer0 sol/eol", {30'd0, lg_mark[0]}, 3);
    chk("R2 xfer1 addr", lg_addr[1], 32'h0000_2040);
    chk("R2 xfer1 count", {20'd0, lg_cnt[1]}, 8);
    chk("R3 xfer1 sol/eol", {30'd0, lg_mark[1]}, 0);
    chk("R5 masked reg2", creg_q[95:64], 32'h1200_5555);
    chk("R5 reg0 untouched", creg_q[31:0], 0);
    chk("R5 reg1 untouched", creg_q[63:32], 0);
    chk("R7 evt after program", {16'd0, evt_cnt}, 3);
    chk("R6 irq1 set", {31'd0, irq1_st}, 1);
    chk("R6 irq2 set", {31'd0, irq2_st}, 1);
    chk("R2 no error", {31'd0, err_st}, 0);
    chk("R4 parked pc", {31'd0, (pc == 16'h0040) || (pc == 16'h0044)}, 1);
    chk("R10 still busy", {31'd0, busy}, 1);
    pulse_stop();
    cyc(5);
    chk("R10 idle after stop", {30'd0, busy, fetch_valid}, 0);
    rdy_mode = 1'b0;

    // scenario 2: write-one-to-clear
    @(negedge clk); irq_clr = 3'b001;
    @(negedge clk); irq_clr = 3'b000;
    chk("R6 irq1 cleared", {31'd0, irq1_st}, 0);
    chk("R6 irq2 kept", {31'd0, irq2_st}, 1);
    @(negedge clk); irq_clr = 3'b010;
    @(negedge clk); irq_clr = 3'b000;
    chk("R6 irq2 cleared", {31'd0, irq2_st}, 0);

    // scenario 3: undefined opcode halts
    pulse_start(16'h0080);
    cyc(10);
    chk("R9 err set", {31'd0, err_st}, 1);
    chk("R9 halted busy", {31'd0, busy}, 0);
    chk("R9 halted fetch", {31'd0, fetch_valid}, 0);
    chk("R9 evt unchanged", {16'd0, evt_cnt}, 3);
    @(negedge clk); irq_clr = 3'b100;
    @(negedge clk); irq_clr = 3'b000;
    chk("R6 err cleared", {31'd0, err_st}, 0);

    // scenario 4: start ignored while busy
    pulse_start(16'h0088);
    cyc(5);
    pulse_start(16'h0080);
    cyc(10);
    chk("R10 start ignored err", {31'd0, err_st}, 0);
    chk("R10 start ignored pc", {31'd0, (pc == 16'h0088) || (pc == 16'h008C)}, 1);
    pulse_stop();
    cyc(4);
    chk("R10 stopped", {31'd0, busy}, 0);

    // scenario 5: counter wrap and buffer-done sweep
    begin
      logic [15:0] prev, cur, offs, dif;
      logic seen_first, wrap_seen;
      logic [15:0] off_tab [0:5];
      off_tab[0] = 16'h0000; off_tab[1] = 16'h0001; off_tab[2] = 16'hFFFF;
      off_tab[3] = 16'h7FFF; off_tab[4] = 16'h8000; off_tab[5] = 16'h8001;
      prev = evt_cnt; seen_first = 1'b0; wrap_seen = 1'b0;
      pulse_start(16'h0090);
      prev = evt_cnt;
      for (int c = 0; c < 90000; c++) begin
        @(negedge clk);
        cur = evt_cnt;
        if (cur != prev) begin
          if (!seen_first) begin
            chk("R7 clear wins", {16'd0, cur}, 0);
            seen_first = 1'b1;
          end else begin
            chk("R7 step by one", {16'd0, cur}, {16'd0, prev + 16'd1});
          end
          if (prev == 16'hFFFF && cur == 16'h0000) wrap_seen = 1'b1;
        end
        offs = off_tab[c % 6];
        buf_target = cur - offs;
        #0.5;
        dif = cur - buf_target;
        chk("R8 buf_done", {31'd0, buf_done}, {31'd0, ~dif[15]});
        prev = cur;
        if (wrap_seen && cur >= 16'd16) break;
      end
      chk("R7 wrap observed", {31'd0, wrap_seen}, 1);
      pulse_stop();
      cyc(4);
      chk("R10 stopped after sweep", {31'd0, busy}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule